// File: doc/BRIEF.md
# Pulse-Count Display Link Receiver

This block sits on the display-panel side of a one-way, three-wire diagnostic link. The sending card drives two control lines, a strobe line and a reset line. The receiver hands a single sense line back to the sender. A character code is not sent as clocked bits. It is sent as a number of strobe pulses. The receiver counts those pulses, keeps the running count in a holding register, and then writes the held code to a parallel display port.

The link carries no clock and sets only minimum pulse widths. The receiver brings both lines into its own fast clock domain through a synchroniser and detects edges there. A five-stage sequencer then tracks the protocol. The stage is chosen only by which edge arrives and in which order. Edges that do not fit the current stage are ignored. A falling edge on the reset line always brings the receiver back to its starting stage.

The sense line is the inverse of the incoming strobe. The sender uses it to detect that the link is present and to check it in real time.

Top module: `disp_link_rx`

## Requirements
- R1: `sense_out` equals the logical inverse of `strobe_in` at all times, including during reset.
- R2: While reset is held and after it is released, `wr_valid` is 0 and `wr_code` is 0 until the first write.
- R3: A falling edge on the reset line returns the receiver to the initial stage from any stage and clears both the pulse counter and the holding register. If this happens in the validate/reset stage, the pending character is dropped without any write.
- R4: In the initial stage, a falling strobe edge while the reset line is low enters the count/latch stage with the counter at 1. After that, each falling strobe edge in the count/latch stage adds one to the counter.
- R5: In the count/latch stage, each rising strobe edge copies the counter into the holding register. The written code is therefore the counter value at the last rising strobe before the reset line rises.
- R6: A rising reset edge in the count/latch stage enters the validate/reset stage. It clears the counter and leaves the holding register unchanged.
- R7: A falling strobe edge in the validate/reset stage, with the reset line high, produces exactly one write: `wr_valid` is high for a single clock cycle and `wr_code` carries the held code.
- R8: The counter is 8 bits wide and wraps modulo 256 without saturating. For example, 256 pulses write code 0 and 257 pulses write code 1.
- R9: Edges that do not fit the current stage have no effect. These are:
  - a rising reset edge in the initial stage;
  - a strobe edge in the initial stage while the reset line is high;
  - a rising strobe edge in the validate/reset stage;
  - any strobe edge in the validate/hold stage.
  None of them produces a write.
- R10: Decoding is correct for any edge spacing of at least two clock cycles, including irregular and long gaps.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Receiver system clock, much faster than the link's minimum pulse width |
| rst_n | input | 1 | Active-low synchronous reset |
| strobe_in | input | 1 | Asynchronous strobe line from the sender |
| reset_in | input | 1 | Asynchronous reset line from the sender |
| sense_out | output | 1 | Inverse of the strobe line, returned to the sender |
| wr_valid | output | 1 | Single-cycle display write pulse |
| wr_code | output | CODE_W | Held code presented to the display with the write |

## Verification
The bench builds the block with its default parameters:
- `CODE_W` = 8, so the wrap at 256 pulses is reached with a few thousand cycles of stimulus;
- `SYNC_STAGES` = 2.

With these values, characters of 1, 5, 37, 255, 256 and 257 pulses can be sent, and the bench can check both the wrap and the value just before it. Edge gaps vary from two cycles to several dozen. This exercises the synchroniser latency against both tight and slow senders. The bench also covers aborts and out-of-stage edges, and confirms that the holding register is cleared and that stray strobes write nothing.

// File: rtl/disp_link_pkg.sv
package disp_link_pkg;

    // Stage encoding; the order of these stages is the link protocol
    typedef enum logic [2:0] {
        ST_INIT   = 3'd0,
        ST_COUNT  = 3'd1,
        ST_VALRST = 3'd2,
        ST_WRITE  = 3'd3,
        ST_HOLD   = 3'd4
    } link_stage_e;

    // Lane positions of the two incoming control lines
    localparam int LANE_STB = 0;
    localparam int LANE_RST = 1;
    localparam int N_LANES  = 2;

endpackage

// File: rtl/link_sync.sv
module link_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic level,
    output logic rise,
    output logic fall
);
    // Synchroniser flops plus one history flop for edge detection
    localparam int DEPTH = STAGES + 1;

    logic [DEPTH-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[DEPTH-2:0], din};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign level = sh_q[STAGES-1];
    assign rise  =  sh_q[STAGES-1] & ~sh_q[STAGES];
    assign fall  = ~sh_q[STAGES-1] &  sh_q[STAGES];

endmodule

// File: rtl/link_seq.sv
module link_seq
    import disp_link_pkg::*;
#(
    parameter int CODE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stb_lvl,
    input  logic              stb_rise,
    input  logic              stb_fall,
    input  logic              rst_lvl,
    input  logic              rst_rise,
    input  logic              rst_fall,
    output logic              wr_valid,
    output logic [CODE_W-1:0] wr_code
);
    localparam logic [CODE_W-1:0] ONE = CODE_W'(1);

    typedef struct packed {
        link_stage_e       stage;
        logic [CODE_W-1:0] cnt;
        logic [CODE_W-1:0] hold;
        logic              wr_valid;
        logic [CODE_W-1:0] wr_code;
    } seq_st_t;

    seq_st_t st_d, st_q;

    always_comb begin
        st_d          = st_q;
        st_d.wr_valid = 1'b0;
        if (rst_fall) begin
            // Return to initial from anywhere and clear all receiver state
            st_d.stage = ST_INIT;
            st_d.cnt   = '0;
            st_d.hold  = '0;
        end else begin
            case (st_q.stage)
                ST_INIT: begin
                    if (stb_fall && !rst_lvl) begin
                        st_d.stage = ST_COUNT;
                        st_d.cnt   = ONE;
                    end
                end
                ST_COUNT: begin
                    if (stb_rise) st_d.hold = st_q.cnt;
                    if (rst_rise) begin
                        st_d.stage = ST_VALRST;
                        st_d.cnt   = '0;
                    end else if (stb_fall) begin
                        st_d.cnt = st_q.cnt + ONE;
                    end
                end
                ST_VALRST: begin
                    if (stb_fall && rst_lvl) begin
                        st_d.stage    = ST_WRITE;
                        st_d.wr_valid = 1'b1;
                        st_d.wr_code  = st_q.hold;
                    end
                end
                ST_WRITE: begin
                    if (stb_rise && stb_lvl) st_d.stage = ST_HOLD;
                end
                ST_HOLD: begin
                    st_d.stage = ST_HOLD;
                end
                default: st_d.stage = ST_INIT;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.stage    <= ST_INIT;
            st_q.cnt      <= '0;
            st_q.hold     <= '0;
            st_q.wr_valid <= 1'b0;
            st_q.wr_code  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign wr_valid = st_q.wr_valid;
    assign wr_code  = st_q.wr_code;

    assert_clear_on_rst_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rst_fall |=> (st_q.stage == ST_INIT && st_q.cnt == '0 && st_q.hold == '0));

    assert_count_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.stage == ST_COUNT && stb_fall && !rst_fall && !rst_rise)
        |=> st_q.cnt == $past(st_q.cnt) + ONE);

    assert_latch_count_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.stage == ST_COUNT && stb_rise && !rst_fall) |=> st_q.hold == $past(st_q.cnt));

    assert_enter_valrst_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.stage == ST_COUNT && rst_rise && !rst_fall)
        |=> (st_q.stage == ST_VALRST && st_q.cnt == '0));

    assert_single_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.wr_valid |=> !st_q.wr_valid);

    assert_write_carries_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.wr_valid |-> (st_q.wr_code == $past(st_q.hold) && st_q.stage == ST_WRITE));

    assert_hold_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.stage != ST_COUNT && !rst_fall) |=> $stable(st_q.hold));

endmodule

// File: rtl/disp_link_rx.sv
module disp_link_rx
    import disp_link_pkg::*;
#(
    parameter int CODE_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strobe_in,
    input  logic              reset_in,
    output logic              sense_out,
    output logic              wr_valid,
    output logic [CODE_W-1:0] wr_code
);
    logic [N_LANES-1:0] lane_in, lane_lvl, lane_rise, lane_fall;

    assign lane_in[LANE_STB] = strobe_in;
    assign lane_in[LANE_RST] = reset_in;

    for (genvar g = 0; g < N_LANES; g++) begin : g_lane
        link_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk   (clk),
            .rst_n (rst_n),
            .din   (lane_in[g]),
            .level (lane_lvl[g]),
            .rise  (lane_rise[g]),
            .fall  (lane_fall[g])
        );
    end

    link_seq #(.CODE_W(CODE_W)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .stb_lvl  (lane_lvl[LANE_STB]),
        .stb_rise (lane_rise[LANE_STB]),
        .stb_fall (lane_fall[LANE_STB]),
        .rst_lvl  (lane_lvl[LANE_RST]),
        .rst_rise (lane_rise[LANE_RST]),
        .rst_fall (lane_fall[LANE_RST]),
        .wr_valid (wr_valid),
        .wr_code  (wr_code)
    );

    // Sense line mirrors the raw strobe, inverted, with no clocking
    assign sense_out = ~strobe_in;

endmodule

// File: tb/tb_disp_link_rx.sv
module tb_disp_link_rx;
    localparam int CODE_W = 8;
    localparam int MOD    = 1 << CODE_W;
    localparam int M_INIT = 0, M_COUNT = 1, M_VALRST = 2, M_WRITE = 3, M_HOLD = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic strobe_in = 1'b1;
    logic reset_in = 1'b0;
    logic sense_out, wr_valid;
    logic [CODE_W-1:0] wr_code;

    int n_checks = 0, n_fail = 0;
    bit done = 1'b0;

    // Behavioural model state
    int mstage = M_INIT, mcnt = 0, mhold = 0;
    int exp_q[$];
    string tag_q[$];
    string cur_tag = "R7";
    int seed = 32'h1234_5678;
    int fixed_gap = 0;

    always #5 clk = ~clk;

    disp_link_rx #(.CODE_W(CODE_W), .SYNC_STAGES(2)) dut (
        .clk(clk), .rst_n(rst_n), .strobe_in(strobe_in), .reset_in(reset_in),
        .sense_out(sense_out), .wr_valid(wr_valid), .wr_code(wr_code)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check(sense_out === ~strobe_in, "R1 sense", int'(sense_out), int'(~strobe_in));
            if (wr_valid) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R9 unexpected write", int'(wr_code), -1);
                end else begin
                    check(int'(wr_code) == exp_q[0], tag_q[0], int'(wr_code), exp_q[0]);
                    void'(exp_q.pop_front());
                    void'(tag_q.pop_front());
                end
            end
        end
    end

    task automatic gap_wait();
        int g;
        if (fixed_gap != 0) begin
            g = fixed_gap;
        end else begin
            seed = seed * 1103515245 + 12345;
            g = 2 + ((seed >>> 16) & 7);
        end
        repeat (g) @(posedge clk);
        #1;
    endtask

    task automatic set_stb(input bit v);
        if (v != strobe_in) begin
            if (!v) begin
                if (mstage == M_INIT && !reset_in) begin
                    mstage = M_COUNT;
                    mcnt = 1;
                end else if (mstage == M_COUNT) begin
                    mcnt = (mcnt + 1) % MOD;
                end else if (mstage == M_VALRST) begin
                    mstage = M_WRITE;
                    exp_q.push_back(mhold);
                    tag_q.push_back(cur_tag);
                end
            end else begin
                if (mstage == M_COUNT) mhold = mcnt;
                else if (mstage == M_WRITE) mstage = M_HOLD;
            end
        end
        strobe_in = v;
        gap_wait();
    endtask

    task automatic set_rst(input bit v);
        if (v != reset_in) begin
            if (!v) begin
                mstage = M_INIT;
                mcnt = 0;
                mhold = 0;
            end else if (mstage == M_COUNT) begin
                mstage = M_VALRST;
                mcnt = 0;
            end
        end
        reset_in = v;
        gap_wait();
    endtask

    task automatic drained(input string tag);
        repeat (8) @(posedge clk);
        #1;
        check(exp_q.size() == 0, {tag, " write missing"}, exp_q.size(), 0);
    endtask

    task automatic send_char(input int n, input string tag);
        cur_tag = tag;
        for (int i = 0; i < n; i++) begin
            set_stb(1'b0);
            set_stb(1'b1);
        end
        set_rst(1'b1);
        set_stb(1'b0);
        set_stb(1'b1);
        set_rst(1'b0);
        drained(tag);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        check(1'b0, "watchdog", 0, 1);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        #1;
        check(wr_valid == 1'b0, "R2 reset wr_valid", int'(wr_valid), 0);
        check(wr_code == '0, "R2 reset wr_code", int'(wr_code), 0);
        check(sense_out == 1'b0, "R1 sense in reset", int'(sense_out), 0);
        rst_n = 1'b1;
        repeat (6) @(posedge clk);
        #1;
        check(wr_valid == 1'b0 && wr_code == '0, "R2 after release", int'(wr_code), 0);

        // Main function: counts become codes
        send_char(1, "R4 one pulse");
        send_char(5, "R5 five pulses");
        send_char(37, "R7 code 37");

        // Wrap modulo 256
        send_char(255, "R8 code 255");
        send_char(256, "R8 wrap to 0");
        send_char(257, "R8 wrap to 1");

        // Ignored edges: reset rise in initial, strobe pulses with reset high
        cur_tag = "R9 stray";
        set_rst(1'b1);
        set_stb(1'b0);
        set_stb(1'b1);
        set_rst(1'b0);
        drained("R9 reset pulse in initial");

        // Extra strobe pulses in validate/hold write nothing more
        cur_tag = "R9 hold extra";
        for (int i = 0; i < 3; i++) begin
            set_stb(1'b0);
            set_stb(1'b1);
        end
        set_rst(1'b1);
        set_stb(1'b0);
        set_stb(1'b1);
        set_stb(1'b0);
        set_stb(1'b1);
        set_stb(1'b0);
        set_stb(1'b1);
        set_rst(1'b0);
        drained("R9 hold extra");

        // Reset rises with strobe low: hold keeps last latched count; rise in validate/reset ignored
        cur_tag = "R6 hold kept";
        set_stb(1'b0);
        set_stb(1'b1);
        set_stb(1'b0);
        set_stb(1'b1);
        set_stb(1'b0);
        set_rst(1'b1);
        set_stb(1'b1);
        set_stb(1'b0);
        set_stb(1'b1);
        set_rst(1'b0);
        drained("R6 hold kept");

        // Abort in validate/reset drops the character
        cur_tag = "R3 abort";
        for (int i = 0; i < 4; i++) begin
            set_stb(1'b0);
            set_stb(1'b1);
        end
        set_rst(1'b1);
        set_rst(1'b0);
        drained("R3 abort no write");

        // Hold cleared by reset fall: one fall, no latch, then write gives 0
        send_char(9, "R5 code 9");
        cur_tag = "R3 hold cleared";
        set_rst(1'b1);
        set_rst(1'b0);
        set_stb(1'b0);
        set_rst(1'b1);
        set_stb(1'b1);
        set_stb(1'b0);
        set_stb(1'b1);
        set_rst(1'b0);
        drained("R3 hold cleared");

        // Irregular and long gaps
        fixed_gap = 40;
        send_char(3, "R10 long gaps");
        fixed_gap = 2;
        send_char(11, "R10 tight gaps");
        fixed_gap = 0;
        send_char(20, "R10 irregular");

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule